// File: doc/BRIEF.md
# Oscillator Clock Loss Monitor

This block runs on a free-running reference clock and watches a second, oscillator clock that is treated as a plain data input. The oscillator line passes through a short synchronizer. Every rising edge seen after the synchronizer reloads a down-counter. If the counter runs out before another edge arrives, the oscillator is taken to be missing, and the block raises a one-cycle fail event.

The check is coarse. It only asks whether edges are arriving at all, and it does not measure frequency. A single enable input gates the whole function, and the block is silent while that input is low.

A response-select input decides what a fail event asks the rest of the chip to do. When it is high, the block raises a self-clock-mode request, which stays high until a clear input or reset removes it. When it is low, the block issues a one-cycle system reset request. Producing the substitute clock and sequencing the reset are left to other logic.

Top module: `clkLossMonitor`

## Requirements
- R1: With the enable high and no synchronized rising oscillator edge, `failPulse` goes high exactly TIMEOUT_CYCLES+1 reference clock edges after the first edge that samples the enable high.
- R2: A synchronized rising oscillator edge reloads the timeout. Rising edges spaced at most TIMEOUT_CYCLES reference cycles apart never cause a fail event. An oscillator input stuck low or stuck high does cause one.
- R3: While the enable is low, no fail event, reset request or new self-clock request is produced. Dropping the enable and raising it again restarts the full timeout.
- R4: `failPulse` is high for a single cycle. It does not repeat until a rising oscillator edge has been seen again, after which a later loss is reported again.
- R5: When `selfClkMode` is 1 in the cycle a fail is detected, `scmReq` is set and stays high until cleared.
- R6: When `selfClkMode` is 0 in the cycle a fail is detected, `rstReq` pulses high for one cycle, in the same cycle as `failPulse`, and `scmReq` is unaffected.
- R7: A high `scmClear` clears `scmReq` on the next edge. If a new self-clock fail arrives in the same cycle, setting wins.
- R8: While the active-low reset is asserted, and right after it, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscIn | input | 1 | Monitored oscillator clock, asynchronous to refClk |
| monEnable | input | 1 | 1 enables the monitor; 0 keeps it silent |
| selfClkMode | input | 1 | Response on fail: 1 requests self-clock mode, 0 requests reset |
| scmClear | input | 1 | Clears the sticky self-clock request |
| failPulse | output | 1 | One-cycle clock-loss event |
| scmReq | output | 1 | Sticky self-clock-mode request |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
The monitor is driven with oscillators whose edge spacing is well inside the timeout and close to it, which separates a correct reload from a counter that ignores edges or reloads late. It is also driven with inputs stuck low and stuck high, showing that a level alone is not read as clock activity. Each loss case is run with both response settings and with the enable low, which separates the two output paths from each other and from the disabled state. Directed cases measure the exact timeout latency. They also check re-arming after a single recovered edge, a mid-count disable, and a clear that coincides with a new fail.

// File: rtl/clk_mon_pkg.sv
package clk_mon_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic run;
  } monCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic edgeSeen;
    logic expired;
  } monStat_t;

endpackage

// File: rtl/clkMonDatapath.sv
module clkMonDatapath
  import clk_mon_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic     refClk,
  input  logic     rstN,
  input  logic     oscIn,
  input  monCtl_t  ctl,
  output monStat_t stat
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TIMEOUT_CYCLES);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   oscPrev;
  logic [CNT_W-1:0]       remain;

  // synchronizer stages
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge refClk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= oscIn;
        end
      end else begin : g_next
        always_ff @(posedge refClk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) oscPrev <= 1'b0;
    else       oscPrev <= syncChain[SYNC_STAGES-1];
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                     remain <= LOAD_VAL;
    else if (ctl.reload)           remain <= LOAD_VAL;
    else if (ctl.run && remain != '0) remain <= remain - 1'b1;
  end

  always_comb begin
    stat.edgeSeen = syncChain[SYNC_STAGES-1] & ~oscPrev;
    stat.expired  = (remain == '0);
  end

endmodule

// File: rtl/clkMonControl.sv
module clkMonControl
  import clk_mon_pkg::*;
(
  input  logic     refClk,
  input  logic     rstN,
  input  logic     monEnable,
  input  logic     selfClkMode,
  input  logic     scmClear,
  input  monStat_t stat,
  output monCtl_t  ctl,
  output logic     failPulse,
  output logic     scmReq,
  output logic     rstReq
);

  logic armed;
  logic fire;

  always_comb begin
    ctl.reload = ~monEnable | stat.edgeSeen;
    ctl.run    = monEnable;
    fire       = monEnable & stat.expired & armed & ~stat.edgeSeen;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                            armed <= 1'b1;
    else if (!monEnable || stat.edgeSeen) armed <= 1'b1;
    else if (fire)                        armed <= 1'b0;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      failPulse <= 1'b0;
      rstReq    <= 1'b0;
      scmReq    <= 1'b0;
    end else begin
      failPulse <= fire;
      rstReq    <= fire & ~selfClkMode;
      if (fire && selfClkMode) scmReq <= 1'b1;
      else if (scmClear)       scmReq <= 1'b0;
    end
  end

endmodule

// File: rtl/clkLossMonitor.sv
module clkLossMonitor
  import clk_mon_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic oscIn,
  input  logic monEnable,
  input  logic selfClkMode,
  input  logic scmClear,
  output logic failPulse,
  output logic scmReq,
  output logic rstReq
);

  monCtl_t  ctlBus;
  monStat_t statBus;

  clkMonDatapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) dp_i (
    .refClk(refClk),
    .rstN  (rstN),
    .oscIn (oscIn),
    .ctl   (ctlBus),
    .stat  (statBus)
  );

  clkMonControl ctl_i (
    .refClk     (refClk),
    .rstN       (rstN),
    .monEnable  (monEnable),
    .selfClkMode(selfClkMode),
    .scmClear   (scmClear),
    .stat       (statBus),
    .ctl        (ctlBus),
    .failPulse  (failPulse),
    .scmReq     (scmReq),
    .rstReq     (rstReq)
  );

endmodule

// File: rtl/clkLossMonitor_chk.sv
module clkLossMonitor_chk (
  input logic refClk,
  input logic rstN,
  input logic monEnable,
  input logic selfClkMode,
  input logic scmClear,
  input logic failPulse,
  input logic scmReq,
  input logic rstReq
);

  // R3
  disabled_silent_chk: assert property (@(posedge refClk) disable iff (!rstN)
    !monEnable |=> (!failPulse && !rstReq));

  // R4
  fail_single_cycle_chk: assert property (@(posedge refClk) disable iff (!rstN)
    failPulse |=> !failPulse);

  // R6
  rst_follows_mode_chk: assert property (@(posedge refClk) disable iff (!rstN)
    failPulse |-> (rstReq == !$past(selfClkMode)));

  // R6
  rst_needs_fail_chk: assert property (@(posedge refClk) disable iff (!rstN)
    rstReq |-> failPulse);

  // R5
  scm_set_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (failPulse && $past(selfClkMode)) |-> scmReq);

  // R5
  scm_rise_cause_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(scmReq) |-> failPulse);

  // R7
  scm_hold_chk: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(scmReq) && !$past(scmClear)) |-> scmReq);

endmodule

bind clkLossMonitor clkLossMonitor_chk chk_i (
  .refClk     (refClk),
  .rstN       (rstN),
  .monEnable  (monEnable),
  .selfClkMode(selfClkMode),
  .scmClear   (scmClear),
  .failPulse  (failPulse),
  .scmReq     (scmReq),
  .rstReq     (rstReq)
);

// File: tb/clkLossMonitor_tb_top.sv
`timescale 1ns/1ps
module clkLossMonitor_tb_top;

  localparam int TMO = 16;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic oscIn = 1'b0;
  logic monEnable = 1'b0;
  logic selfClkMode = 1'b0;
  logic scmClear = 1'b0;
  logic failPulse, scmReq, rstReq;

  int total = 0;
  int bad = 0;

  // oscillator generator: half period in ref cycles, 0 = hold oscLevel
  int   oscHalf = 0;
  logic oscLevel = 1'b0;
  int   oscCnt = 0;

  always #4 refClk = ~refClk;

  always @(negedge refClk) begin
    if (oscHalf != 0) begin
      if (oscCnt >= oscHalf - 1) begin
        oscIn  <= ~oscIn;
        oscCnt <= 0;
      end else begin
        oscCnt <= oscCnt + 1;
      end
    end else begin
      oscIn  <= oscLevel;
      oscCnt <= 0;
    end
  end

  clkLossMonitor #(.TIMEOUT_CYCLES(TMO)) dut_i (
    .refClk(refClk), .rstN(rstN), .oscIn(oscIn), .monEnable(monEnable),
    .selfClkMode(selfClkMode), .scmClear(scmClear),
    .failPulse(failPulse), .scmReq(scmReq), .rstReq(rstReq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       en;
    logic       mode;
    logic [3:0] half;
    logic       level;
    logic [1:0] expFail;
    logic [1:0] expRst;
    logic       expScm;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 4'd3, 1'b0, 2'd0, 2'd0, 1'b0},  // fast osc, reset mode
    '{1'b1, 1'b1, 4'd7, 1'b0, 2'd0, 2'd0, 1'b0},  // near-limit osc
    '{1'b1, 1'b0, 4'd0, 1'b0, 2'd1, 2'd1, 1'b0},  // stuck low, reset mode
    '{1'b1, 1'b1, 4'd0, 1'b1, 2'd1, 2'd0, 1'b1},  // stuck high, self-clock
    '{1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 2'd0, 1'b0},  // disabled, reset mode
    '{1'b0, 1'b1, 4'd0, 1'b1, 2'd0, 2'd0, 1'b0}   // disabled, self-clock
  };

  task automatic quiesce();
    @(negedge refClk);
    monEnable = 1'b0; oscHalf = 0; oscLevel = 1'b0; scmClear = 1'b1;
    @(negedge refClk);
    scmClear = 1'b0;
    repeat (4) @(negedge refClk);
  endtask

  // wait for failPulse, returning negedges waited (limit returns -1)
  task automatic waitFail(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge refClk);
      if (failPulse) begin n = i; break; end
    end
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int fails, rsts;
    // R8 reset state
    repeat (3) @(negedge refClk);
    check("R8 failPulse in reset", failPulse, 0);
    check("R8 scmReq in reset", scmReq, 0);
    check("R8 rstReq in reset", rstReq, 0);
    rstN = 1'b1;
    @(negedge refClk);
    check("R8 outputs after reset", {failPulse, scmReq, rstReq}, 0);

    // vector table: R2, R3, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      quiesce();
      monEnable   = VECS[v].en;
      selfClkMode = VECS[v].mode;
      oscHalf     = VECS[v].half;
      oscLevel    = VECS[v].level;
      fails = 0; rsts = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge refClk);
        fails += failPulse;
        rsts  += rstReq;
      end
      check($sformatf("R2/R3 vec%0d fail count", v), fails, VECS[v].expFail);
      check($sformatf("R6 vec%0d reset count", v), rsts, VECS[v].expRst);
      check($sformatf("R5 vec%0d scmReq", v), scmReq, VECS[v].expScm);
    end

    // R1 exact latency
    quiesce();
    selfClkMode = 1'b0;
    monEnable = 1'b1;
    waitFail(60, n);
    check("R1 timeout latency", n, TMO + 1);
    check("R6 rstReq with failPulse", rstReq, 1);
    @(negedge refClk);
    check("R4 failPulse one cycle", failPulse, 0);
    check("R6 rstReq one cycle", rstReq, 0);
    // R4 no repeat without edges
    waitFail(50, n);
    check("R4 no repeat without edge", n, -1);
    // R4 rearm after a single rising edge
    oscLevel = 1'b1;
    waitFail(40, n);
    check("R4 rearm after edge", (n > 0) ? 1 : 0, 1);

    // R3 disable mid-count restarts timeout
    quiesce();
    monEnable = 1'b1;
    repeat (10) @(negedge refClk);
    monEnable = 1'b0;
    repeat (3) @(negedge refClk);
    check("R3 no fail while disabled", failPulse, 0);
    monEnable = 1'b1;
    waitFail(60, n);
    check("R3 restart full timeout", n, TMO + 1);

    // R7 clear and set-wins
    quiesce();
    selfClkMode = 1'b1;
    monEnable = 1'b1;
    waitFail(60, n);
    check("R5 scmReq set", scmReq, 1);
    repeat (5) @(negedge refClk);
    check("R5 scmReq sticky", scmReq, 1);
    scmClear = 1'b1;
    @(negedge refClk);
    scmClear = 1'b0;
    check("R7 clear works", scmReq, 0);
    // coincident clear and fail: rearm by edge, then hold clear on the fire edge
    oscLevel = 1'b1;
    repeat (4) @(negedge refClk);
    // edge seen; fail will appear TMO+1 edges after reload
    for (int i = 0; i < 40; i++) begin
      scmClear = 1'b1;
      @(negedge refClk);
      if (failPulse) break;
    end
    scmClear = 1'b0;
    check("R7 set wins over clear", scmReq, 1);
    check("R7 fail occurred", failPulse, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule